// File: doc/BRIEF.md
# Presettable Two-Digit Decimal Counter

This block is a synchronous up-counter that steps through the decimal values 00 to 99 and holds them as packed BCD in one byte. The tens digit sits in bits [7:4] and the ones digit in bits [3:0], so the output can drive a pair of digit decoders directly. After 99 the next count is 00.

Three controls set what happens at each rising clock edge. An active-low clear empties the counter at once, with no clock needed. An active-high load copies a byte from the parallel input. An active-high enable advances the count by one. The clear wins over the load, and the load wins over the enable. On a load, each input nibble is checked on its own: a nibble that is not a decimal digit (1010 to 1111) is stored as nine, and a valid nibble next to it is stored unchanged. A combinational carry flag is high while the counter reads 99, the enable is high and no load is requested, so a second counter can be chained after this one.

Top module: `bcd2_counter`

## Requirements
- R1: While clr_n is 0, count_o reads 8'h00 at once, without waiting for a clock edge, and it stays 8'h00 across edges until clr_n returns to 1.
- R2: With load_i = 0 and en_i = 1, each rising edge raises the decimal value of count_o by one (for example 37 becomes 38).
- R3: When the ones digit (bits [3:0]) is 9 and a count occurs, the ones digit becomes 0 and the tens digit (bits [7:4]) goes up by one on the same edge (39 becomes 40, 19 becomes 20).
- R4: A count from 8'h99 gives 8'h00 on the next edge.
- R5: With load_i = 0 and en_i = 0, count_o keeps its value across rising edges.
- R6: With load_i = 1, a rising edge stores din_i in count_o when both nibbles are in the range 0 to 9. Nothing is stored between edges.
- R7: On a load, each nibble of din_i in the range 4'hA to 4'hF is stored as 4'h9. The other nibble is not affected, so 8'hA5 gives 8'h95, 8'h3C gives 8'h39 and 8'hFF gives 8'h99.
- R8: When load_i and en_i are both 1, the edge performs the load and does not count.
- R9: When clr_n is 0, load_i = 1 has no effect: count_o stays 8'h00.
- R10: Neither nibble of count_o is ever above 9.
- R11: carry_o is 1 exactly when count_o is 8'h99, en_i is 1 and load_i is 0. It is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all loads and counts happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low; forces the value to 00 |
| load_i | input | 1 | Synchronous parallel load, active high |
| en_i | input | 1 | Count enable, active high |
| din_i | input | 8 | Parallel value, tens in [7:4], ones in [3:0] |
| count_o | output | 8 | Current value as packed BCD, tens in [7:4], ones in [3:0] |
| carry_o | output | 1 | High while the value is 99, the enable is high and no load is requested |

## Verification
A wrong ones-digit register shows up on count_o at the first edge that counts or holds, and a carry chain fault shows up at the first 9-to-0 step of the ones digit. A digit that escapes above nine is reported by the range property on the edge where it appears. A missing clamp on load appears on the edge that performs the load. The complete 00-to-99 sweep with a wrap shows any error in the decade sequence within one step of where it occurs.

// File: rtl/bcd_cnt_pkg.sv
// Package: bcd_cnt_pkg
// Shared digit type and digit-level helpers for the decimal counter.
// Assumes 4-bit BCD digits; the digit count is set by the top module.
package bcd_cnt_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_digit_t;
    localparam bcd_digit_t DIGIT_MAX = 4'd9;

    // Next value of a digit on a count step, wrapping nine to zero.
    function automatic bcd_digit_t digit_step(input bcd_digit_t d);
        return (d == DIGIT_MAX) ? '0 : bcd_digit_t'(d + 1'b1);
    endfunction
endpackage

// File: rtl/bcd_nibble_clamp.sv
// Module: bcd_nibble_clamp
// Makes one parallel-input nibble a legal decimal digit: a code above nine
// becomes nine and any other code passes through. Purely combinational.
module bcd_nibble_clamp
    import bcd_cnt_pkg::*;
(
    input  bcd_digit_t raw_i,
    output bcd_digit_t legal_o
);
    // Clamp codes A..F to nine.
    always_comb begin
        legal_o = (raw_i > DIGIT_MAX) ? DIGIT_MAX : raw_i;
    end
endmodule

// File: rtl/bcd_decade.sv
// Module: bcd_decade
// One decimal digit register with clear, load and step controls.
// Assumes load_val_i is already a legal digit. Priority inside the stage:
// clear, then load, then step. The carry to the next digit is high when
// this digit and every lower one are at nine.
module bcd_decade
    import bcd_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic       load_i,
    input  bcd_digit_t load_val_i,
    input  logic       en_i,
    input  logic       carry_in_i,
    output bcd_digit_t digit_o,
    output logic       carry_out_o
);
    bcd_digit_t digit_q;

    // Digit register: asynchronous clear, then load, then step.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            digit_q <= '0;
        end else if (load_i) begin
            digit_q <= load_val_i;
        end else if (en_i && carry_in_i) begin
            digit_q <= digit_step(digit_q);
        end
    end

    // Pass the carry upward when this digit is at nine.
    always_comb begin
        carry_out_o = carry_in_i && (digit_q == DIGIT_MAX);
    end

    assign digit_o = digit_q;
endmodule

// File: rtl/bcd2_counter.sv
// Module: bcd2_counter
// Presettable decimal up-counter with packed BCD output, the most
// significant digit in the top nibble. Clear is asynchronous and active
// low. Load is synchronous and clamps each nibble to nine on its own.
// Clear wins over load, and load wins over enable. carry_o is combinational.
module bcd2_counter
    import bcd_cnt_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    localparam int W = NUM_DIGITS * DIGIT_W
)(
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_i,
    input  logic         en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] count_o,
    output logic         carry_o
);
    logic [NUM_DIGITS:0] chain;

    assign chain[0] = 1'b1;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        bcd_digit_t legal;
        bcd_digit_t value;

        bcd_nibble_clamp i_clamp (
            .raw_i   (din_i[g*DIGIT_W +: DIGIT_W]),
            .legal_o (legal)
        );

        bcd_decade i_decade (
            .clk         (clk),
            .clr_n       (clr_n),
            .load_i      (load_i),
            .load_val_i  (legal),
            .en_i        (en_i),
            .carry_in_i  (chain[g]),
            .digit_o     (value),
            .carry_out_o (chain[g+1])
        );

        assign count_o[g*DIGIT_W +: DIGIT_W] = value;
    end

    // Chain-out flag: all digits at nine and a count is requested.
    always_comb begin
        carry_o = en_i && !load_i && chain[NUM_DIGITS];
    end
endmodule

// File: rtl/bcd2_counter_chk.sv
// Module: bcd2_counter_chk
// Checker for bcd2_counter, attached by the bind below. It only reads the
// ports of the counter.
module bcd2_counter_chk #(
    parameter int W = 8
)(
    input logic         clk,
    input logic         clr_n,
    input logic         load_i,
    input logic         en_i,
    input logic [W-1:0] din_i,
    input logic [W-1:0] count_o,
    input logic         carry_o
);
    localparam int ND = W / 4;
    localparam logic [W-1:0] ALL_NINE = {ND{4'h9}};

    function automatic int dec_of(input logic [W-1:0] x);
        int v;
        v = 0;
        for (int i = ND - 1; i >= 0; i--) v = v * 10 + int'(x[4*i +: 4]);
        return v;
    endfunction

    function automatic int dec_mod();
        int m;
        m = 1;
        for (int i = 0; i < ND; i++) m = m * 10;
        return m;
    endfunction

    function automatic logic [W-1:0] fix_all(input logic [W-1:0] x);
        logic [W-1:0] r;
        for (int i = 0; i < ND; i++)
            r[4*i +: 4] = (x[4*i +: 4] > 4'd9) ? 4'd9 : x[4*i +: 4];
        return r;
    endfunction

    function automatic logic legal(input logic [W-1:0] x);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < ND; i++) if (x[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    // R1: clear holds the value at zero
    p_clear_zero_r1: assert property (@(posedge clk) !clr_n |-> count_o == '0);

    // R2: one decimal step per enabled edge
    p_step_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (en_i && !load_i) |=> dec_of(count_o) == (dec_of($past(count_o)) + 1) % dec_mod());

    // R4: wrap from all nines to zero
    p_wrap_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (en_i && !load_i && count_o == ALL_NINE) |=> count_o == '0);

    // R5: hold when idle
    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_i && !load_i) |=> $stable(count_o));

    // R7: load stores the clamped input
    p_load_clamp_r7: assert property (@(posedge clk) disable iff (!clr_n)
        load_i |=> count_o == fix_all($past(din_i)));

    // R10: every nibble stays decimal
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!clr_n)
        legal(count_o));

    // R11: carry only at all nines with a real count
    p_carry_cond_r11: assert property (@(posedge clk) disable iff (!clr_n)
        carry_o |-> (count_o == ALL_NINE && en_i && !load_i));

    // R11: carry is followed by zero
    p_carry_next_r11: assert property (@(posedge clk) disable iff (!clr_n)
        carry_o |=> count_o == '0);
endmodule

bind bcd2_counter bcd2_counter_chk #(.W(W)) i_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .load_i  (load_i),
    .en_i    (en_i),
    .din_i   (din_i),
    .count_o (count_o),
    .carry_o (carry_o)
);

// File: tb/test_bcd2_counter.sv
// Bench for bcd2_counter: a vector table walked by one loop, then directed
// tests for the clear, its priority and a full decade sweep.
module test_bcd2_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_i = 1'b0;
    logic       en_i = 1'b0;
    logic [7:0] din_i = 8'h00;
    logic [7:0] count_o;
    logic       carry_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Vector fields: load, enable, din, carry expected before the edge, count after it.
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h37, 1'b0, 8'h37},  // R6
        {1'b0, 1'b1, 8'h00, 1'b0, 8'h38},  // R2
        {1'b0, 1'b1, 8'h00, 1'b0, 8'h39},  // R2
        {1'b0, 1'b1, 8'h00, 1'b0, 8'h40},  // R3
        {1'b0, 1'b0, 8'h55, 1'b0, 8'h40},  // R5
        {1'b1, 1'b1, 8'h98, 1'b0, 8'h98},  // R8
        {1'b0, 1'b1, 8'h00, 1'b0, 8'h99},  // R2
        {1'b0, 1'b1, 8'h00, 1'b1, 8'h00},  // R4 R11
        {1'b1, 1'b0, 8'hA5, 1'b0, 8'h95},  // R7
        {1'b1, 1'b0, 8'h3C, 1'b0, 8'h39},  // R7
        {1'b1, 1'b1, 8'hFF, 1'b0, 8'h99},  // R7
        {1'b1, 1'b1, 8'h12, 1'b0, 8'h12},  // R11 no carry on load
        {1'b1, 1'b0, 8'h19, 1'b0, 8'h19},  // R6
        {1'b0, 1'b1, 8'h00, 1'b0, 8'h20},  // R3
        {1'b1, 1'b0, 8'h99, 1'b0, 8'h99},  // R6
        {1'b0, 1'b0, 8'h00, 1'b0, 8'h99},  // R5 R11 no carry when idle
        {1'b1, 1'b0, 8'h09, 1'b0, 8'h09},  // R6
        {1'b0, 1'b1, 8'h00, 1'b0, 8'h10}   // R3
    };

    bcd2_counter i_bcd2_counter (
        .clk     (clk),
        .clr_n   (clr_n),
        .load_i  (load_i),
        .en_i    (en_i),
        .din_i   (din_i),
        .count_o (count_o),
        .carry_o (carry_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check8("R1", count_o, 8'h00);
        clr_n = 1'b1;
        @(negedge clk);
        check8("R1", count_o, 8'h00);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            load_i = VEC[v][18];
            en_i   = VEC[v][17];
            din_i  = VEC[v][16:9];
            #1;
            check1("R11", carry_o, VEC[v][8]);
            @(posedge clk);
            #1;
            check8($sformatf("vector %0d R2-group", v), count_o, VEC[v][7:0]);
        end

        // R6: load is synchronous, nothing stored between edges
        @(negedge clk);
        load_i = 1'b1; en_i = 1'b0; din_i = 8'h64;
        #2;
        check8("R6", count_o, 8'h10);
        @(posedge clk); #1;
        check8("R6", count_o, 8'h64);

        // R1: clear acts without a clock edge
        @(negedge clk);
        load_i = 1'b0;
        #1 clr_n = 1'b0;
        #1;
        check8("R1", count_o, 8'h00);
        check1("R11", carry_o, 1'b0);

        // R9: clear wins over load across edges
        load_i = 1'b1; en_i = 1'b1; din_i = 8'h77;
        @(posedge clk); #1;
        check8("R9", count_o, 8'h00);
        @(posedge clk); #1;
        check8("R9", count_o, 8'h00);
        @(negedge clk);
        load_i = 1'b0; en_i = 1'b0;
        clr_n = 1'b1;
        @(posedge clk); #1;
        check8("R9", count_o, 8'h00);

        // R2 R3 R4 R10: full sweep from 00 with a wrap
        @(negedge clk);
        en_i = 1'b1;
        for (int k = 1; k <= 101; k++) begin
            @(posedge clk); #1;
            check8("R2 sweep", count_o, {4'((k % 100) / 10), 4'(k % 10)});
            check1("R10", (count_o[7:4] <= 4'd9) && (count_o[3:0] <= 4'd9), 1'b1);
        end
        @(negedge clk);
        en_i = 1'b0;
        @(posedge clk); #1;
        check8("R5", count_o, 8'h01);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule